// File: doc/BRIEF.md
# Lockable Tamper Event-to-Action Router

This block collects security events from up to sixteen sources, fourteen of them hardware lines and two raised by software, and latches each one into a status register. A per-output selection matrix decides which latched events drive each of six response actions: an interrupt, a crypto-engine reset, a key-storage zeroize, a RAM zeroize, a chip reset and an external tamper-out line. Each action is latched as well, and its output line follows the latched bit until software clears that bit.

Each routing choice is held in two redundant 2-bit codes, one in each of two select registers. Only two exact code pairs leave a routing writable: "not routed" and "routed". Every other combination counts as routed and also locks the pair against further writes until reset. A flipped bit therefore errs toward raising the action and never toward silently dropping it.

Software reaches the block through a word-addressed register port. The write side has strobe, address and data. The read side is combinational, so read data follows the address in the same cycle.

Top module: `tamper_router`

## Requirements
- R1: After reset every select register reads 0xAAAAAAAA (every field 2'b10), the status register reads 0 and all six action outputs are low.
- R2: A field pair with first code 2'b10 and second code 2'b10 does not route its event and accepts writes.
- R3: A field pair with first code 2'b01 and second code 2'b10 routes its event and accepts writes.
- R4: A field pair whose second code is anything other than 2'b10 routes its event and is locked, whatever its first code holds.
- R5: A field pair whose first code is 2'b00 or 2'b11 routes its event and is locked, whatever its second code holds.
- R6: A write to a select register changes only the unlocked pairs in it. Locked pairs keep both codes until reset, and the write raises no error.
- R7: Register map: word 2k holds the first codes and word 2k+1 the second codes for output k. Event n sits in bits [2n+1:2n]. Outputs are indexed 0 interrupt, 1 crypto-engine reset, 2 key-storage zeroize, 3 RAM zeroize, 4 chip reset, 5 tamper-out.
- R8: A high level on hardware event input i at a rising edge sets status bit i (i = 0..13) at that edge. The status register is at word 12, with event bits [15:0] and action bits [21:16].
- R9: Status bit 16+k is set one edge after any event bit routed to output k is set, and action output k equals status bit 16+k.
- R10: Writing a 1 to a status bit clears it, and a clear takes priority over a set at the same edge. Writing 0 leaves a bit alone. Bits [31:22] read as 0 and writes to them have no effect.
- R11: The interrupt output (output 0) stays high until status bit 16 is written with 1.
- R12: A nonzero write to word 13 sets status bit 14, and a nonzero write to word 14 sets status bit 15. A zero write to either word does nothing. Both words read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; the only way to clear a lock |
| evt_in | input | 14 | Hardware event lines, level sampled each edge |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| act_out | output | 6 | Action lines, one per output, each following its latched status bit |

## Verification
The routing is tried with every code class: the disabled default, the writable enabled pair, a locked pair made by a bad second code, and locked pairs made by first codes 00 and 11. Each event is fired alone, and the exact six-bit action vector is compared, so a route leaking to the wrong output shows up as well as a missing one. Rewrites of locked pairs that carry new data in both select words tell write protection apart from plain register storage. Clearing only the interrupt bit while its event stays latched, and then clearing both, tells hold-until-clear apart from re-arming. Zero and nonzero software-event writes and writes to reserved status bits show that these are ignored.

// File: rtl/tr_pkg.sv
package tr_pkg;

    typedef enum logic [1:0] {
        RT_IDLE_OPEN   = 2'd0,
        RT_LIVE_OPEN   = 2'd1,
        RT_LIVE_LOCKED = 2'd2
    } route_e;

    localparam logic [1:0] CODE_OFF = 2'b10;
    localparam logic [1:0] CODE_ON  = 2'b01;

    // Only two exact patterns stay open; everything else is routed and locked.
    function automatic route_e decode_pair(input logic [1:0] c0, input logic [1:0] c1);
        route_e r;
        if (c1 != CODE_OFF || c0 == 2'b00 || c0 == 2'b11) r = RT_LIVE_LOCKED;
        else if (c0 == CODE_ON)                           r = RT_LIVE_OPEN;
        else                                              r = RT_IDLE_OPEN;
        return r;
    endfunction

endpackage

// File: rtl/tr_sel_bank.sv
module tr_sel_bank
    import tr_pkg::*;
#(
    parameter int N_IN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr0,
    input  logic              wr1,
    input  logic [2*N_IN-1:0] wdata,
    output logic [2*N_IN-1:0] sel0_q,
    output logic [2*N_IN-1:0] sel1_q,
    output logic [N_IN-1:0]   routed
);

    logic [1:0] code0 [N_IN];
    logic [1:0] code1 [N_IN];

    for (genvar g = 0; g < N_IN; g++) begin : g_pair
        route_e pair_st;

        assign pair_st = decode_pair(code0[g], code1[g]);
        assign routed[g] = (pair_st != RT_IDLE_OPEN);
        assign sel0_q[2*g +: 2] = code0[g];
        assign sel1_q[2*g +: 2] = code1[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code0[g] <= CODE_OFF;
                code1[g] <= CODE_OFF;
            end else if (pair_st != RT_LIVE_LOCKED) begin
                if (wr0) code0[g] <= wdata[2*g +: 2];
                if (wr1) code1[g] <= wdata[2*g +: 2];
            end
        end
    end

endmodule

// File: rtl/tr_status.sv
module tr_status #(
    parameter int N_IN  = 16,
    parameter int N_OUT = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_IN-1:0]             evt_set,
    input  logic [N_IN-1:0]             evt_clr,
    input  logic [N_OUT-1:0]            act_clr,
    input  logic [N_OUT-1:0][N_IN-1:0]  routed,
    output logic [N_IN-1:0]             evt_q,
    output logic [N_OUT-1:0]            act_q
);

    logic [N_OUT-1:0] act_hit;

    for (genvar k = 0; k < N_OUT; k++) begin : g_hit
        assign act_hit[k] = |(evt_q & routed[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
            act_q <= '0;
        end else begin
            evt_q <= (evt_q | evt_set) & ~evt_clr;
            act_q <= (act_q | act_hit) & ~act_clr;
        end
    end

endmodule

// File: rtl/tamper_router.sv
module tamper_router
    import tr_pkg::*;
#(
    parameter int N_IN   = 16,
    parameter int N_OUT  = 6,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_IN-3:0]     evt_in,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [N_OUT-1:0]    act_out
);

    localparam int SEL_W     = 2 * N_IN;
    localparam int STAT_W    = N_IN + N_OUT;
    localparam int STAT_ADDR = 2 * N_OUT;
    localparam int SWA_ADDR  = 2 * N_OUT + 1;
    localparam int SWB_ADDR  = 2 * N_OUT + 2;

    logic [N_OUT-1:0][SEL_W-1:0] sel0_w;
    logic [N_OUT-1:0][SEL_W-1:0] sel1_w;
    logic [N_OUT-1:0][N_IN-1:0]  routed_w;
    logic [N_IN-1:0]             evt_q;
    logic [N_OUT-1:0]            act_q;
    logic                        stat_wr;
    logic                        swa_hit;
    logic                        swb_hit;
    logic [N_IN-1:0]             evt_set;

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        logic wr0_k;
        logic wr1_k;
        assign wr0_k = bus_we && (bus_addr == ADDR_W'(2 * k));
        assign wr1_k = bus_we && (bus_addr == ADDR_W'(2 * k + 1));

        tr_sel_bank #(.N_IN(N_IN)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr0    (wr0_k),
            .wr1    (wr1_k),
            .wdata  (bus_wdata[SEL_W-1:0]),
            .sel0_q (sel0_w[k]),
            .sel1_q (sel1_w[k]),
            .routed (routed_w[k])
        );
    end

    assign stat_wr = bus_we && (bus_addr == ADDR_W'(STAT_ADDR));
    assign swa_hit = bus_we && (bus_addr == ADDR_W'(SWA_ADDR)) && (|bus_wdata);
    assign swb_hit = bus_we && (bus_addr == ADDR_W'(SWB_ADDR)) && (|bus_wdata);
    assign evt_set = {swb_hit, swa_hit, evt_in};

    tr_status #(.N_IN(N_IN), .N_OUT(N_OUT)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_set (evt_set),
        .evt_clr (stat_wr ? bus_wdata[N_IN-1:0] : '0),
        .act_clr (stat_wr ? bus_wdata[N_IN +: N_OUT] : '0),
        .routed  (routed_w),
        .evt_q   (evt_q),
        .act_q   (act_q)
    );

    assign act_out = act_q;

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < N_OUT; k++) begin
            if (bus_addr == ADDR_W'(2 * k))     bus_rdata[SEL_W-1:0] = sel0_w[k];
            if (bus_addr == ADDR_W'(2 * k + 1)) bus_rdata[SEL_W-1:0] = sel1_w[k];
        end
        if (bus_addr == ADDR_W'(STAT_ADDR)) bus_rdata[STAT_W-1:0] = {act_q, evt_q};
    end

endmodule

// File: rtl/tr_checker.sv
module tr_checker
    import tr_pkg::*;
#(
    parameter int N_IN   = 16,
    parameter int N_OUT  = 6,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_we,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [DATA_W-1:0]             bus_wdata,
    input logic [DATA_W-1:0]             bus_rdata,
    input logic [N_OUT-1:0]              act_out,
    input logic [N_IN-1:0]               evt_q,
    input logic [N_OUT-1:0][2*N_IN-1:0]  sel0_w,
    input logic [N_OUT-1:0][2*N_IN-1:0]  sel1_w,
    input logic [N_OUT-1:0][N_IN-1:0]    routed_w
);

    localparam int STAT_W    = N_IN + N_OUT;
    localparam int STAT_ADDR = 2 * N_OUT;
    localparam int SWA_ADDR  = 2 * N_OUT + 1;

    for (genvar k = 0; k < N_OUT; k++) begin : g_k
        for (genvar f = 0; f < N_IN; f++) begin : g_f
            // R6: a locked pair never changes while reset is inactive
            a_r6_locked_pair_stable: assert property (@(posedge clk) disable iff (!rst_n)
                (decode_pair(sel0_w[k][2*f +: 2], sel1_w[k][2*f +: 2]) == RT_LIVE_LOCKED)
                |=> ({sel0_w[k][2*f +: 2], sel1_w[k][2*f +: 2]}
                     == $past({sel0_w[k][2*f +: 2], sel1_w[k][2*f +: 2]})));
        end

        // R9: an action only rises after a routed event was latched
        a_r9_action_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(act_out[k]) |-> $past(|(evt_q & routed_w[k])));
    end

    // R11: interrupt holds unless its status bit is written with 1
    a_r11_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (act_out[0] && !(bus_we && bus_addr == ADDR_W'(STAT_ADDR) && bus_wdata[N_IN]))
        |=> act_out[0]);

    // R12: a zero write to the first software-event word raises nothing
    a_r12_sw_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(SWA_ADDR) && bus_wdata == '0 && !evt_q[N_IN-2])
        |=> !evt_q[N_IN-2]);

    // R10: reserved status bits always read zero
    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(STAT_ADDR)) |-> (bus_rdata[DATA_W-1:STAT_W] == '0));

endmodule

bind tamper_router tr_checker #(
    .N_IN(N_IN), .N_OUT(N_OUT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .act_out   (act_out),
    .evt_q     (evt_q),
    .sel0_w    (sel0_w),
    .sel1_w    (sel1_w),
    .routed_w  (routed_w)
);

// File: tb/tamper_router_tb.sv
module tamper_router_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] evt_in = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  act_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tamper_router u_dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .act_out(act_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input int i);
        @(negedge clk);
        evt_in[i] = 1'b1;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic clear_all();
        wr(4'd12, 32'hFFFF_FFFF);
        step(1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 12; a++) begin
            rd(4'(a), d);
            chk("R1 R7 select reset value", d, 32'hAAAA_AAAA);
        end
        rd(4'd12, d);
        chk("R1 status reset", d, 32'h0);
        chk("R1 actions low", {26'h0, act_out}, 32'h0);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        pulse(0);
        step(1);
        rd(4'd12, d);
        chk("R8 event latched", d, 32'h0000_0001);
        chk("R2 default pair not routed", {26'h0, act_out}, 32'h0);
        wr(4'd12, 32'h0000_0001);
        rd(4'd12, d);
        chk("R10 w1c clears event", d, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(4'd0, 32'hAAAA_AA6A);
        rd(4'd0, d);
        chk("R3 open pair writable", d, 32'hAAAA_AA6A);
        pulse(3);
        step(1);
        chk("R3 R9 irq raised", {26'h0, act_out}, 32'h1);
        rd(4'd12, d);
        chk("R9 action status bit", d, 32'h0001_0008);
        wr(4'd12, 32'hFFC0_0000);
        rd(4'd12, d);
        chk("R10 reserved write ignored", d, 32'h0001_0008);
        step(5);
        chk("R11 irq held", {26'h0, act_out}, 32'h1);
        wr(4'd12, 32'h0001_0000);
        chk("R10 action cleared", {26'h0, act_out}, 32'h0);
        step(1);
        chk("R11 rearmed by latched event", {26'h0, act_out}, 32'h1);
        wr(4'd12, 32'h0001_0008);
        step(2);
        chk("R11 irq released", {26'h0, act_out}, 32'h0);
    endtask

    task automatic t_lock_sel1();
        logic [31:0] d;
        wr(4'd9, 32'hAAAA_A2AA);
        rd(4'd9, d);
        chk("R4 second code written", d, 32'hAAAA_A2AA);
        wr(4'd9, 32'hAAAA_9AAA);
        rd(4'd9, d);
        chk("R6 locked kept, open updated", d, 32'hAAAA_92AA);
        wr(4'd8, 32'hAAAA_A6AA);
        rd(4'd8, d);
        chk("R6 locked first code kept", d, 32'hAAAA_AAAA);
        pulse(5);
        step(1);
        chk("R4 chip reset routed", {26'h0, act_out}, 32'h10);
        clear_all();
        pulse(6);
        step(1);
        chk("R4 second locked pair routes", {26'h0, act_out}, 32'h10);
        clear_all();
    endtask

    task automatic t_lock_sel0();
        logic [31:0] d;
        wr(4'd10, 32'hAAAA_AA8A);
        wr(4'd11, 32'hAAAA_AA9A);
        rd(4'd11, d);
        chk("R5 R6 partner code locked", d, 32'hAAAA_AAAA);
        wr(4'd10, 32'hAAAA_AAAA);
        rd(4'd10, d);
        chk("R5 R6 first code 00 kept", d, 32'hAAAA_AA8A);
        pulse(2);
        step(1);
        chk("R5 tamper-out routed", {26'h0, act_out}, 32'h20);
        clear_all();
        wr(4'd6, 32'hAAAA_AAAB);
        wr(4'd6, 32'hAAAA_AAAA);
        rd(4'd6, d);
        chk("R5 first code 11 locked", d, 32'hAAAA_AAAB);
        pulse(0);
        step(1);
        chk("R5 RAM zeroize routed", {26'h0, act_out}, 32'h08);
        clear_all();
    endtask

    task automatic t_sw();
        logic [31:0] d;
        wr(4'd2, 32'h6AAA_AAAA);
        wr(4'd13, 32'h0);
        rd(4'd12, d);
        chk("R12 zero write ignored", d, 32'h0);
        wr(4'd13, 32'h0000_0005);
        rd(4'd12, d);
        chk("R12 sw event A", d, 32'h0000_4000);
        rd(4'd13, d);
        chk("R12 sw word reads 0", d, 32'h0);
        clear_all();
        wr(4'd14, 32'h8000_0000);
        step(1);
        chk("R12 sw event B routed to crypto reset", {26'h0, act_out}, 32'h02);
        clear_all();
    endtask

    task automatic t_rereset();
        logic [31:0] d;
        pulse(5);
        step(1);
        @(negedge clk); rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        rd(4'd9, d);
        chk("R6 reset clears lock", d, 32'hAAAA_AAAA);
        rd(4'd10, d);
        chk("R6 reset clears lock 2", d, 32'hAAAA_AAAA);
        chk("R1 actions low after reset", {26'h0, act_out}, 32'h0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_disabled();
        t_irq();
        t_lock_sel1();
        t_lock_sel0();
        t_sw();
        t_rereset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule